// File: doc/BRIEF.md
# Interval Timer Byte Access Sequencer

This block is the byte-wide register front end of a three-channel interval timer. A 2-bit address picks channel 0, 1 or 2. Writes to a channel load its initial count, and reads from a channel return one byte of its running count, of a frozen count snapshot, or of a captured status byte. Each channel has a 2-bit access mode: low byte only, high byte only, or a low-then-high word. The block keeps the per-channel byte order for both directions. Two-byte writes use a holding register.

Each channel has a plain 16-bit down-counter, so that reads return live values. The counter reloads from its initial count and steps once per enable tick while its gate is high. The status byte contents, the access mode and the mode-programming pulse all come from an external control decoder.

Read results appear on a registered output one cycle after the access. Accesses that are not one byte wide are dropped. A read of address 3 returns all ones and leaves every channel untouched.

Top module: `tmr_bus_front`

## Requirements
- R1: After reset every channel's count and initial count are 0, `unprog` is 3'b111, `gate` is 3'b011 and `rd_valid` is low.
- R2: An access with `acc_bytes` other than 1 is ignored. It produces no `rd_valid`, loads no count and does not advance any byte sequence.
- R3: A one-byte read of address 3 returns 8'hFF and changes no channel state. A write to address 3 has no effect.
- R4: A write in mode 1 (low byte) loads {8'h00, byte}. A write in mode 2 (high byte) loads {byte, 8'h00}. The count and the initial count both take the loaded value.
- R5: In mode 3 (word), the first written byte is held and nothing is loaded. The second byte loads {second, first}, and the next write is a first byte again.
- R6: Each accepted one-byte read raises `rd_valid` for exactly one cycle, on the cycle after the access, with the byte on `rd_data`.
- R7: With nothing latched, a read returns the live count: its low byte in mode 1 and its high byte in mode 2. In mode 3 it returns the low byte and the high byte on alternate reads, starting with the low byte.
- R8: A `cnt_latch` pulse copies the live count into a snapshot only if no snapshot is pending. Reads of a pending snapshot return its low byte (mode 1) or its high byte (mode 2), then release it. In mode 3 they return the low byte and then the high byte, and then release it.
- R9: A `stat_latch` pulse captures the channel's `stat_in` byte if no status is pending. The next read of that channel returns it and clears it, ahead of any pending count snapshot.
- R10: On each cycle with `tick` high and the channel gate high, the count decrements. A count of 1 reloads the initial count instead, so an initial count of 0 gives a period of 65536. A write load takes precedence over a tick.
- R11: Gates of channels 0 and 1 are always high. The gate of channel 2 follows `gate2` one cycle later.
- R12: A `mode_set` pulse on a channel clears its `unprog` bit and returns both its read and its write sequence to the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_bytes | input | 3 | Access width in bytes; only 1 is accepted |
| acc_addr | input | 2 | Channel select; 3 is not a channel |
| acc_wdata | input | DW | Write byte |
| rd_data | output | DW | Read byte, registered |
| rd_valid | output | 1 | Read result strobe |
| rw_mode | input | 6 | Access mode per channel, 2 bits each, channel 0 in bits 1:0 |
| mode_set | input | 3 | Per-channel programming pulse |
| cnt_latch | input | 3 | Per-channel count snapshot strobe |
| stat_latch | input | 3 | Per-channel status capture strobe |
| stat_in | input | 3*DW | Status byte per channel, channel 0 in the low byte |
| tick | input | 1 | Count enable tick |
| gate2 | input | 1 | Gate request for channel 2 |
| unprog | output | 3 | Per-channel not-yet-programmed marker |
| gate | output | 3 | Effective gate per channel |

## Verification
The bench reads channels in each of the three access modes. Repeated reads in word mode show the toggling byte order, while repeated reads in single-byte modes must not toggle. It interleaves new count writes with pending snapshots and status captures, so that latched and live bytes differ and a wrong priority shows up as a wrong value. It sends wide accesses, address-3 reads and a mid-word `mode_set`, and then checks that the byte order continues exactly where it should. Counts of 3, 0 and 5 are ticked with the gate open and closed, which separates reload-at-1, the 65536 period and a stalled gate.

// File: rtl/tmr_bus_front.sv
module tmr_bus_front #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [2:0]      acc_bytes,
  input  logic [1:0]      acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  input  logic [5:0]      rw_mode,
  input  logic [2:0]      mode_set,
  input  logic [2:0]      cnt_latch,
  input  logic [2:0]      stat_latch,
  input  logic [3*DW-1:0] stat_in,
  input  logic            tick,
  input  logic            gate2,
  output logic [2:0]      unprog,
  output logic [2:0]      gate
);
  localparam int CW = 2 * DW;
  localparam int NCH = 3;
  localparam logic [1:0] RW_LO = 2'd1, RW_HI = 2'd2, RW_WORD = 2'd3;

  logic [NCH-1:0][CW-1:0] cnt, init, snap;
  logic [NCH-1:0][DW-1:0] hold, sbyte, rbyte;
  logic [NCH-1:0][1:0]    cpend;
  logic [NCH-1:0]         wr_hi, rd_hi, spend;
  logic                   g2_q;

  wire byte_ok = acc_en && (acc_bytes == 3'd1);
  wire wr_go   = byte_ok && acc_wr;
  wire rd_go   = byte_ok && !acc_wr;

  assign gate = {g2_q, 2'b11};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    wire [1:0] m      = rw_mode[2*ch +: 2];
    wire       sel    = (acc_addr == ch[1:0]);
    wire       wr_hit = wr_go && sel;
    wire       rd_hit = rd_go && sel;
    logic          ld;
    logic [CW-1:0] ldv;

    always_comb begin
      ld  = 1'b0;
      ldv = {CW{1'b0}};
      if (wr_hit) begin
        case (m)
          RW_HI:   begin ld = 1'b1;        ldv = {acc_wdata, {DW{1'b0}}}; end
          RW_WORD: begin ld = wr_hi[ch];   ldv = {acc_wdata, hold[ch]};   end
          default: begin ld = 1'b1;        ldv = {{DW{1'b0}}, acc_wdata}; end
        endcase
      end
    end

    always_comb begin
      if (spend[ch])
        rbyte[ch] = sbyte[ch];
      else if (cpend[ch] != 2'd0)
        rbyte[ch] = (cpend[ch] == RW_HI) ? snap[ch][CW-1:DW] : snap[ch][DW-1:0];
      else if (m == RW_HI || (m == RW_WORD && rd_hi[ch]))
        rbyte[ch] = cnt[ch][CW-1:DW];
      else
        rbyte[ch] = cnt[ch][DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[ch]    <= '0;
        init[ch]   <= '0;
        snap[ch]   <= '0;
        hold[ch]   <= '0;
        sbyte[ch]  <= '0;
        cpend[ch]  <= 2'd0;
        wr_hi[ch]  <= 1'b0;
        rd_hi[ch]  <= 1'b0;
        spend[ch]  <= 1'b0;
        unprog[ch] <= 1'b1;
      end else begin
        if (mode_set[ch]) begin
          wr_hi[ch]  <= 1'b0;
          rd_hi[ch]  <= 1'b0;
          unprog[ch] <= 1'b0;
        end else begin
          if (wr_hit && m == RW_WORD) begin
            if (!wr_hi[ch]) hold[ch] <= acc_wdata;
            wr_hi[ch] <= !wr_hi[ch];
          end
          if (rd_hit && !spend[ch] && cpend[ch] == 2'd0 && m == RW_WORD)
            rd_hi[ch] <= !rd_hi[ch];
        end

        if (ld) begin
          init[ch] <= ldv;
          cnt[ch]  <= ldv;
        end else if (tick && gate[ch]) begin
          cnt[ch] <= (cnt[ch] == CW'(1)) ? init[ch] : cnt[ch] - CW'(1);
        end

        if (rd_hit && spend[ch])
          spend[ch] <= 1'b0;
        else if (stat_latch[ch] && !spend[ch]) begin
          spend[ch] <= 1'b1;
          sbyte[ch] <= stat_in[DW*ch +: DW];
        end

        if (rd_hit && !spend[ch] && cpend[ch] != 2'd0)
          cpend[ch] <= (cpend[ch] == RW_WORD) ? RW_HI : 2'd0;
        else if (cnt_latch[ch] && cpend[ch] == 2'd0) begin
          cpend[ch] <= (m == 2'd0) ? RW_LO : m;
          snap[ch]  <= cnt[ch];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      g2_q     <= 1'b0;
    end else begin
      g2_q     <= gate2;
      rd_valid <= rd_go;
      if (rd_go) begin
        case (acc_addr)
          2'd0:    rd_data <= rbyte[0];
          2'd1:    rd_data <= rbyte[1];
          2'd2:    rd_data <= rbyte[2];
          default: rd_data <= {DW{1'b1}};
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [2:0]    acc_bytes,
  input logic [1:0]    acc_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          tick,
  input logic          gate2,
  input logic [2:0]    gate,
  input logic [2*DW-1:0] cnt0
);
  wire rd_ok  = acc_en && !acc_wr && (acc_bytes == 3'd1);
  wire any_wr = acc_en && acc_wr;

  AST_WIDE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_bytes != 3'd1) |=> !rd_valid); // R2
  AST_ADDR3_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && acc_addr == 2'd3) |=> (rd_data == {DW{1'b1}})); // R3
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rd_valid); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !rd_valid); // R6
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_wr) |=> $stable(cnt0)); // R10
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_wr && cnt0 > 16'd1) |=> (cnt0 == $past(cnt0) - 16'd1)); // R10
  AST_LOW_GATES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    gate[1:0] == 2'b11); // R11
  AST_GATE2_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    gate2 |=> gate[2]); // R11
endmodule

bind tmr_bus_front tmr_bus_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_bytes(acc_bytes), .acc_addr(acc_addr), .rd_data(rd_data),
  .rd_valid(rd_valid), .tick(tick), .gate2(gate2), .gate(gate),
  .cnt0(cnt[0])
);

// File: tb/tb_tmr_bus_front.sv
module tb_tmr_bus_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [2:0]  acc_bytes = 3'd1;
  logic [1:0]  acc_addr = 2'd0;
  logic [7:0]  acc_wdata = 8'h00;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [5:0]  rw_mode = 6'b01_10_01;
  logic [2:0]  mode_set = '0, cnt_latch = '0, stat_latch = '0;
  logic [23:0] stat_in = 24'h00A500;
  logic        tick = 1'b0, gate2 = 1'b0;
  logic [2:0]  unprog, gate;

  tmr_bus_front dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] e_byte;
  string      e_tag;
  bit         done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected rd_valid", 32'd1, 32'd0);
      else begin
        e_byte = exp_q.pop_front();
        e_tag  = tag_q.pop_front();
        check(e_tag, {24'd0, rd_data}, {24'd0, e_byte});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [2:0] nb = 3'd1);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_bytes = nb;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_bytes = 3'd1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_bytes = 3'd1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic strobe(input logic [2:0] cl, input logic [2:0] sl, input logic [2:0] ms, input logic tk);
    @(negedge clk);
    cnt_latch = cl; stat_latch = sl; mode_set = ms; tick = tk;
    @(negedge clk);
    cnt_latch = '0; stat_latch = '0; mode_set = '0; tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 unprog", {29'd0, unprog}, 32'b111);
    check("R1 gate", {29'd0, gate}, 32'b011);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rd(2'd0, 8'h00, "R1 count zero");

    wr(2'd0, 8'h5A);
    rd(2'd0, 8'h5A, "R4 low-byte load");
    wr(2'd1, 8'h3C);
    rd(2'd1, 8'h3C, "R4 high-byte load");
    rd(2'd1, 8'h3C, "R7 high mode no toggle");
    rw_mode[3:2] = 2'd1;
    rd(2'd1, 8'h00, "R4 high-byte load clears low byte");

    rw_mode[1:0] = 2'd3;
    strobe(3'b000, 3'b000, 3'b001, 1'b0);
    check("R12 unprog cleared", {29'd0, unprog}, 32'b110);
    wr(2'd0, 8'h34);
    wr(2'd0, 8'h12);
    rd(2'd0, 8'h34, "R5 word low");
    rd(2'd0, 8'h12, "R5 word high");
    rd(2'd0, 8'h34, "R7 word toggles back");
    wr(2'd0, 8'h99, 3'd2);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 2'd0; acc_bytes = 3'd2;
    @(negedge clk);
    acc_en = 1'b0; acc_bytes = 3'd1;
    check("R2 wide read no rd_valid", {31'd0, rd_valid}, 32'd0);
    rd(2'd0, 8'h12, "R2 wide accesses ignored");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'hFF, "R3 address 3 read");
    rd(2'd0, 8'h34, "R3 no state change");
    rd(2'd0, 8'h12, "R3 sequence intact");

    strobe(3'b001, 3'b000, 3'b000, 1'b0);
    wr(2'd0, 8'h78);
    wr(2'd0, 8'h56);
    strobe(3'b001, 3'b000, 3'b000, 1'b0);
    rd(2'd0, 8'h34, "R8 snapshot low");
    rd(2'd0, 8'h12, "R8 snapshot high, second strobe ignored");
    rd(2'd0, 8'h78, "R8 released, live low");
    rd(2'd0, 8'h56, "R8 live high");

    wr(2'd1, 8'h77);
    strobe(3'b010, 3'b010, 3'b000, 1'b0);
    wr(2'd1, 8'h11);
    rd(2'd1, 8'hA5, "R9 status first");
    rd(2'd1, 8'h77, "R8 snapshot after status");
    rd(2'd1, 8'h11, "R9 live after both");
    rw_mode[3:2] = 2'd2;
    wr(2'd1, 8'h99);
    strobe(3'b010, 3'b000, 3'b000, 1'b0);
    wr(2'd1, 8'h11);
    rd(2'd1, 8'h99, "R8 high-mode snapshot");
    rd(2'd1, 8'h11, "R8 high-mode released");

    wr(2'd0, 8'h03);
    wr(2'd0, 8'h00);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    rd(2'd0, 8'h01, "R10 decrement low");
    rd(2'd0, 8'h00, "R10 decrement high");
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    rd(2'd0, 8'h03, "R10 reload at one");
    rd(2'd0, 8'h00, "R10 reload high");
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    rd(2'd0, 8'hFF, "R10 zero wraps low");
    rd(2'd0, 8'hFF, "R10 zero wraps high");

    wr(2'd2, 8'h05);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    rd(2'd2, 8'h05, "R11 gate low holds count");
    check("R11 gate before", {29'd0, gate}, 32'b011);
    gate2 = 1'b1;
    @(negedge clk);
    check("R11 gate follows", {29'd0, gate}, 32'b111);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    strobe(3'b000, 3'b000, 3'b000, 1'b1);
    rd(2'd2, 8'h03, "R11 gate high counts");

    wr(2'd0, 8'hEE);
    strobe(3'b000, 3'b000, 3'b001, 1'b0);
    wr(2'd0, 8'h21);
    wr(2'd0, 8'h43);
    rd(2'd0, 8'h21, "R12 write sequence restarted");
    rd(2'd0, 8'h43, "R12 word high");
    rd(2'd0, 8'h21, "R12 low before reset");
    strobe(3'b000, 3'b000, 3'b001, 1'b0);
    rd(2'd0, 8'h21, "R12 read sequence restarted");

    repeat (3) @(negedge clk);
    check("R6 all reads answered", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule